// File: doc/BRIEF.md
# NOR Flash Command Controller

This block is a synthesizable device-side model of a parallel NOR flash command interface. It sits on a small on-chip word array. A host issues single-cycle bus writes and reads. The controller decodes the writes into unlock sequences and commands: read-array reset, word program, unlock-bypass program, sector erase, chip erase, and erase suspend/resume. Program and erase run as simplified embedded sequences whose lengths are set by parameters.

While an operation runs, reads return a status word instead of array data. Bit 7 carries the inverted-data polling flag. Bit 6 flips on every read. A busy output stays high for the whole operation. Sector protection comes in as one lock bit per sector. The asynchronous reset aborts any operation and leaves the array as it stands.

The array is a scaled-down top-boot map. Its default depth is 256 words, in units of one word. Addresses 0–247 form thirty-one 8-word sectors (0–30). Addresses 248–251 form sector 31, 252 is sector 32, 253 is sector 33, and 254–255 is sector 34. This keeps the 32:16:4:4:8 proportions of the large and boot sectors.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After reset `busy_o` is 0 and no command is pending. A read strobe with no operation running loads `bus_rdata` with the addressed array word at the next clock edge.
- R2: A normal program is four writes (data on bits 7:0, default 8-bit address): AAh to 55h, 55h to AAh, A0h to 55h, then the target address with the data word. `busy_o` is then high for exactly PROG_CYC cycles, and the word becomes its old value ANDed with the new data.
- R3: A write that does not match the expected unlock cycle or command byte returns the controller to read mode. That includes an F0h command, which is the explicit read-array reset. The array is not modified and `busy_o` stays low.
- R4: The writes AAh to 55h, 55h to AAh, 20h to 55h enter bypass mode. In bypass mode, A0h at any address followed by address/data programs a word, and the controller returns to bypass mode afterwards. Any other write (such as F0h) leaves bypass mode, after which a bare A0h and data write programs nothing.
- R5: A read while busy returns a status word with bits 15:8 and 5:0 zero. Bit 7 is the complement of bit 7 of the data being programmed during a program, and 0 during an erase.
- R6: Bit 6 of the status word inverts on each successive read while busy. After the operation completes, reads return array data.
- R7: `busy_o` rises only in the cycle after a bus write and stays high for the whole operation. An erase holds it for ERASE_DLY + 2·DEPTH cycles.
- R8: Asserting `rst_n` during a program aborts it: the target word keeps its old value, `busy_o` is low, and a following program works normally.
- R9: Sector erase is the six writes AAh/55h/80h/AAh/55h, then 30h to any address in the sector. It sets every word of exactly that sector, per the map above, to FFFFh and leaves all other words unchanged.
- R10: Chip erase is the six writes ending with 10h to 55h. It sets every word of every unlocked sector to FFFFh.
- R11: A program or erase whose target sector has its `sec_lock` bit set is inhibited. `busy_o` stays low and the array is unchanged. Locked sectors are skipped by chip erase.
- R12: An erase first writes 0000h over every word of the selected sectors, then writes FFFFh over them.
- R13: Writing B0h during an erase suspends it. `busy_o` falls, reads return array data, and a normal program to a sector outside the erase runs. Writing 30h resumes the erase, which then completes.
- R14: While suspended, a program aimed at a sector selected for erase is inhibited and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the hardware abort |
| bus_wr | input | 1 | Single-cycle bus write strobe |
| bus_rd | input | 1 | Single-cycle bus read strobe |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wdata | input | DATA_W (16) | Write data; command byte on bits 7:0 |
| sec_lock | input | 35 | Per-sector protect bits, sector index order |
| bus_rdata | output | DATA_W (16) | Registered read data or status word |
| busy_o | output | 1 | High while a program or erase is running |

## Verification
The array is first erased and filled with an address-derived pattern. Even words are written through the four-cycle program and odd words through bypass, so a mix-up between the two paths shows as wrong words. Every one of the 35 sectors is then erased in turn and the whole array is read back each time. This separates a correct sector decode from one that spills into a neighbour or misses a boot sector. Broken unlock sequences are tried (wrong data, wrong address, unknown command byte, explicit F0h reset), as are locked targets and programs during suspend. In each case a stray write would show as a busy pulse or a changed word. Polling reads during program data with bit 7 set and with bit 7 clear tell true polling apart from a constant flag. A suspend placed between the two erase passes shows the zero preprogram, which the final all-ones result would otherwise hide.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  localparam int UNITS  = 256;
  localparam int NSECT  = 35;
  localparam int SECT_W = 6;

  localparam logic [7:0] CMD_UNL1  = 8'hAA;
  localparam logic [7:0] CMD_UNL2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_BYP   = 8'h20;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_RES   = 8'h30;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PWAIT, S_PRUN, S_BYP, S_BYPA,
    S_E0, S_E1, S_E2, S_ERUN, S_SUSP
  } cmd_state_e;

  typedef enum logic [1:0] {W_IDLE, W_WAIT, W_PRE, W_ERS} walk_e;

  // Top-boot map in smallest units: 31 sectors of 8 units, then 4, 1, 1, 2.
  function automatic logic [SECT_W-1:0] unit_to_sect(input logic [7:0] u);
    if (u < 8'd248)      return {1'b0, u[7:3]};
    else if (u < 8'd252) return 6'd31;
    else if (u == 8'd252) return 6'd32;
    else if (u == 8'd253) return 6'd33;
    else                 return 6'd34;
  endfunction

endpackage

// File: rtl/nor_sect_map.sv
module nor_sect_map
  import nor_flash_pkg::*;
#(
  parameter int UNIT_LOG2 = 0,
  parameter int ADDR_W    = 8 + UNIT_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SECT_W-1:0] sect
);
  assign sect = unit_to_sect(addr[ADDR_W-1 -: 8]);
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  output logic [DATA_W-1:0] rdata0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/nor_erase_walk.sv
module nor_erase_walk
  import nor_flash_pkg::*;
#(
  parameter int UNIT_LOG2 = 0,
  parameter int ADDR_W    = 8 + UNIT_LOG2,
  parameter int DATA_W    = 16,
  parameter int ERASE_DLY = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start,
  input  logic [NSECT-1:0]  mask_in,
  input  logic              run,
  output logic [NSECT-1:0]  sel_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = (ERASE_DLY > 1) ? $clog2(ERASE_DLY + 1) : 1;
  localparam logic [ADDR_W-1:0] PTR_LAST = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(ERASE_DLY - 1);

  walk_e             phase, phase_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic [NSECT-1:0]  mask, mask_n;
  logic [SECT_W-1:0] sect_ptr;

  nor_sect_map #(.UNIT_LOG2(UNIT_LOG2), .ADDR_W(ADDR_W)) u_map_ptr (
    .addr (ptr),
    .sect (sect_ptr)
  );

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    ptr_n   = ptr;
    mask_n  = mask;
    if (start) begin
      phase_n = W_WAIT;
      cnt_n   = '0;
      ptr_n   = '0;
      mask_n  = mask_in;
    end else if (run) begin
      case (phase)
        W_WAIT: begin
          if (cnt == CNT_LAST) phase_n = W_PRE;
          else                 cnt_n   = cnt + 1'b1;
        end
        W_PRE: begin
          ptr_n = ptr + 1'b1;
          if (ptr == PTR_LAST) phase_n = W_ERS;
        end
        W_ERS: begin
          ptr_n = ptr + 1'b1;
          if (ptr == PTR_LAST) phase_n = W_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= W_IDLE;
      cnt   <= '0;
      ptr   <= '0;
      mask  <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      ptr   <= ptr_n;
      mask  <= mask_n;
    end
  end

  assign sel_o   = mask;
  assign wr_en   = run && (phase == W_PRE || phase == W_ERS) && mask[sect_ptr];
  assign wr_addr = ptr;
  assign wr_data = (phase == W_PRE) ? '0 : '1;
  assign done    = run && (phase == W_ERS) && (ptr == PTR_LAST);
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_flash_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int UNIT_LOG2 = 0,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_DLY = 16,
  parameter int ADDR_W    = 8 + UNIT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSECT-1:0]  sec_lock,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy_o
);
  localparam int PCNT_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PROG_CYC - 1);
  localparam logic [ADDR_W-1:0] UNL_A1 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UNL_A2 = ADDR_W'(12'h2AA);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  cmd_state_e        st, st_n;
  logic              byp, byp_n, susp, susp_n, tog;
  logic [PCNT_W-1:0] pcnt, pcnt_n;
  logic [ADDR_W-1:0] pa;
  logic [DATA_W-1:0] pd;
  logic              ld_prog, ers_start, ers_done, prog_we, prog_ok;
  logic [NSECT-1:0]  ers_mask, ers_sel;
  logic [SECT_W-1:0] sect_bus;
  logic [7:0]        cmd;
  logic              at_u1, at_u2;
  cmd_state_e        ret_st, after_prog;

  logic              walk_we;
  logic [ADDR_W-1:0] walk_addr, mem_waddr;
  logic [DATA_W-1:0] walk_data, mem_wdata, arr_bus, arr_pa, stat_w, rd_val;
  logic              mem_we;

  nor_sect_map #(.UNIT_LOG2(UNIT_LOG2), .ADDR_W(ADDR_W)) u_map_bus (
    .addr (bus_addr),
    .sect (sect_bus)
  );

  nor_erase_walk #(
    .UNIT_LOG2 (UNIT_LOG2),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ERASE_DLY (ERASE_DLY)
  ) u_walk (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .start   (ers_start),
    .mask_in (ers_mask),
    .run     (st == S_ERUN),
    .sel_o   (ers_sel),
    .wr_en   (walk_we),
    .wr_addr (walk_addr),
    .wr_data (walk_data),
    .done    (ers_done)
  );

  nor_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .raddr0 (bus_addr),
    .rdata0 (arr_bus),
    .raddr1 (pa),
    .rdata1 (arr_pa)
  );

  assign cmd   = bus_wdata[7:0];
  assign at_u1 = (bus_addr == UNL_A1);
  assign at_u2 = (bus_addr == UNL_A2);

  assign prog_we   = (st == S_PRUN) && (pcnt == PCNT_LAST);
  assign mem_we    = prog_we || walk_we;
  assign mem_waddr = prog_we ? pa : walk_addr;
  assign mem_wdata = prog_we ? (arr_pa & pd) : walk_data;

  assign busy_o = (st == S_PRUN) || (st == S_ERUN);

  // Command sequencer: next state.
  always_comb begin
    st_n       = st;
    byp_n      = byp;
    susp_n     = susp;
    pcnt_n     = pcnt;
    ld_prog    = 1'b0;
    ers_start  = 1'b0;
    ers_mask   = '0;
    ret_st     = susp ? S_SUSP : S_READ;
    after_prog = byp ? S_BYP : ret_st;
    prog_ok    = !sec_lock[sect_bus] && !(susp && ers_sel[sect_bus]);
    case (st)
      S_READ: if (bus_wr && cmd == CMD_UNL1 && at_u1) st_n = S_U1;
      S_U1:   if (bus_wr) st_n = (cmd == CMD_UNL2 && at_u2) ? S_U2 : ret_st;
      S_U2: begin
        if (bus_wr) begin
          st_n = ret_st;
          if (at_u1) begin
            if (cmd == CMD_PROG) begin
              st_n = S_PWAIT;
            end else if (!susp && cmd == CMD_SETUP) begin
              st_n = S_E0;
            end else if (!susp && cmd == CMD_BYP) begin
              st_n  = S_BYP;
              byp_n = 1'b1;
            end
          end
        end
      end
      S_PWAIT, S_BYPA: begin
        if (bus_wr) begin
          if (prog_ok) begin
            st_n    = S_PRUN;
            ld_prog = 1'b1;
            pcnt_n  = '0;
          end else begin
            st_n = after_prog;
          end
        end
      end
      S_PRUN: begin
        if (pcnt == PCNT_LAST) st_n   = after_prog;
        else                   pcnt_n = pcnt + 1'b1;
      end
      S_BYP: begin
        if (bus_wr) begin
          if (cmd == CMD_PROG) begin
            st_n = S_BYPA;
          end else begin
            st_n  = S_READ;
            byp_n = 1'b0;
          end
        end
      end
      S_E0: if (bus_wr) st_n = (cmd == CMD_UNL1 && at_u1) ? S_E1 : S_READ;
      S_E1: if (bus_wr) st_n = (cmd == CMD_UNL2 && at_u2) ? S_E2 : S_READ;
      S_E2: begin
        if (bus_wr) begin
          st_n = S_READ;
          if (cmd == CMD_CHIP && at_u1) ers_mask = ~sec_lock;
          else if (cmd == CMD_SECT)     ers_mask = (NSECT'(1) << sect_bus) & ~sec_lock;
          if (|ers_mask) begin
            st_n      = S_ERUN;
            ers_start = 1'b1;
          end
        end
      end
      S_ERUN: begin
        if (ers_done) begin
          st_n = S_READ;
        end else if (bus_wr && cmd == CMD_SUSP) begin
          st_n   = S_SUSP;
          susp_n = 1'b1;
        end
      end
      S_SUSP: begin
        if (bus_wr) begin
          if (cmd == CMD_RES) begin
            st_n   = S_ERUN;
            susp_n = 1'b0;
          end else if (cmd == CMD_UNL1 && at_u1) begin
            st_n = S_U1;
          end
        end
      end
      default: st_n = S_READ;
    endcase
  end

  // Status word: polling flag on bit 7, toggle on bit 6.
  always_comb begin
    stat_w    = '0;
    stat_w[7] = (st == S_PRUN) ? ~pd[7] : 1'b0;
    stat_w[6] = tog;
    rd_val    = busy_o ? stat_w : arr_bus;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= S_READ;
      byp       <= 1'b0;
      susp      <= 1'b0;
      pcnt      <= '0;
      tog       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      st   <= st_n;
      byp  <= byp_n;
      susp <= susp_n;
      pcnt <= pcnt_n;
      if (bus_rd) begin
        bus_rdata <= rd_val;
        if (busy_o) tog <= ~tog;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_prog) begin
      pa <= bus_addr;
      pd <= bus_wdata;
    end
  end
endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int ERASE_DLY = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              busy_o
);
  localparam int MAX_BUSY = ERASE_DLY + 2 * (1 << ADDR_W);

  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= '0;
  end

  // R7: a busy period only starts right after a bus write
  p_busy_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(bus_wr));

  // R7: no operation holds busy longer than a full erase
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= MAX_BUSY);

  // R5: status word carries only the polling and toggle bits
  p_status_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && busy_o) |=> (bus_rdata[DATA_W-1:8] == '0 && bus_rdata[5:0] == '0));

  // R6: back-to-back status reads see bit 6 flip
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && busy_o && $past(bus_rd && busy_o)) |=> (bus_rdata[6] != $past(bus_rdata[6])));
endmodule

bind nor_flash_ctrl nor_flash_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .ERASE_DLY (ERASE_DLY)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .busy_o    (busy_o)
);

// File: tb/test_nor_flash_ctrl.sv
module test_nor_flash_ctrl;
  localparam int CLK_P     = 10;
  localparam int PROG_CYC  = 8;
  localparam int ERASE_DLY = 16;
  localparam int DEPTH     = 256;
  localparam int ERASE_T   = ERASE_DLY + 2 * DEPTH;
  localparam int WD_CYC    = 200000;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [34:0] sec_lock;
  logic [15:0] bus_rdata;
  logic        busy_o;

  int tests;
  int fails;
  logic [15:0] model [DEPTH];

  nor_flash_ctrl #(
    .DATA_W(16), .UNIT_LOG2(0), .PROG_CYC(PROG_CYC), .ERASE_DLY(ERASE_DLY)
  ) i_nor_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sec_lock(sec_lock),
    .bus_rdata(bus_rdata), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  function automatic int sect_of(input int a);
    if (a < 248) return a / 8;
    if (a < 252) return 31;
    if (a == 252) return 32;
    if (a == 253) return 33;
    return 34;
  endfunction

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 40503) ^ 16'h01F3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o === 1'b1 && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic prog(input int a, input int d);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre;
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h80);
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55);
  endtask

  task automatic check_all(input string req);
    int bad;
    int fa;
    logic [15:0] fv;
    logic [15:0] v;
    bad = 0; fa = 0; fv = '0;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      if (v !== model[a]) begin
        if (bad == 0) begin fa = a; fv = v; end
        bad++;
      end
    end
    chk(bad == 0, req, fv, model[fa]);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] v, s1, s2;
    tests = 0; fails = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; sec_lock = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);

    // R10 / R7: chip erase of the whole array, exact busy length
    erase_pre(); wr(8'h55, 8'h10);
    busy_len(n);
    chk(n == ERASE_T, "R7 erase busy length", n, ERASE_T);
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
    check_all("R10 chip erase all ones");

    // R2: four-cycle program on even words
    for (int a = 0; a < DEPTH; a += 2) begin
      prog(a, pat(a));
      busy_len(n);
      if (a == 0) chk(n == PROG_CYC, "R2 program busy length", n, PROG_CYC);
      model[a] = pat(a);
    end
    // R4: bypass program on odd words
    wr(8'h55, 8'hAA); wr(8'hAA, 8'h55); wr(8'h55, 8'h20);
    for (int a = 1; a < DEPTH; a += 2) begin
      wr(0, 8'hA0); wr(a, pat(a));
      busy_len(n);
      if (a == 1) chk(n == PROG_CYC, "R4 bypass busy length", n, PROG_CYC);
      model[a] = pat(a);
    end
    wr(0, 8'hF0);
    wr(0, 8'hA0); wr(3, 16'h0000);
    chk(busy_o == 1'b0, "R4 no program after bypass exit", busy_o, 0);
    check_all("R1 R2 R4 pattern readback");

    // R2: AND of old and new data
    prog(5, 16'h0FF0); busy_len(n);
    model[5] = pat(5) & 16'h0FF0;
    rd(5, v);
    chk(v == model[5], "R2 program ANDs old and new", v, model[5]);

    // R5 / R6: polling during program, data bit 7 set then clear
    prog(10, 16'h0080);
    rd(10, s1); rd(10, s2);
    chk(s1[7] == 1'b0 && s1[15:8] == 8'h00 && s1[5:0] == 6'h00,
        "R5 poll bit7 for data bit7=1", s1, 16'h0000);
    chk(s1[6] != s2[6], "R6 toggle differs", s2[6], !s1[6]);
    busy_len(n);
    model[10] = pat(10) & 16'h0080;
    rd(10, v);
    chk(v == model[10], "R6 data after completion", v, model[10]);
    prog(11, 16'h7F00);
    rd(11, s1);
    chk(s1[7] == 1'b1 && s1[15:8] == 8'h00, "R5 poll bit7 for data bit7=0", s1, 16'h0080);
    busy_len(n);
    model[11] = pat(11) & 16'h7F00;

    // R3: broken sequences leave word 2 unchanged
    for (int k = 0; k < 4; k++) begin
      wr(8'h55, 8'hAA);
      case (k)
        0: begin wr(8'hAA, 8'h12); wr(8'h55, 8'hA0); end
        1: begin wr(8'h33, 8'h55); wr(8'h55, 8'hA0); end
        2: begin wr(8'hAA, 8'h55); wr(8'h55, 8'h77); end
        default: begin wr(8'hAA, 8'h55); wr(8'h55, 8'hF0); end
      endcase
      wr(2, 16'h0000);
      chk(busy_o == 1'b0, "R3 no busy after broken sequence", busy_o, 0);
      rd(2, v);
      chk(v == model[2], "R3 word unchanged", v, model[2]);
    end
    prog(2, 16'h0000); busy_len(n); model[2] = 16'h0000;
    rd(2, v);
    chk(v == 16'h0000, "R3 program after recovery", v, 0);

    // R11: locked sector 5 (addresses 40..47)
    sec_lock = 35'd1 << 5;
    prog(42, 16'h0000);
    chk(busy_o == 1'b0, "R11 locked program not busy", busy_o, 0);
    erase_pre(); wr(44, 8'h30);
    chk(busy_o == 1'b0, "R11 locked erase not busy", busy_o, 0);
    rd(42, v);
    chk(v == model[42], "R11 locked word unchanged", v, model[42]);
    sec_lock = '0;

    // R9: erase every sector in turn, full readback each time
    for (int s = 0; s < 35; s++) begin
      int ta;
      ta = (s < 31) ? s * 8 + 7 : (s == 31) ? 251 : (s == 32) ? 252 : (s == 33) ? 253 : 255;
      erase_pre(); wr(ta, 8'h30);
      if (s == 0) begin
        rd(0, s1); rd(0, s2);
        chk(s1[7] == 1'b0 && s1[15:8] == 8'h00, "R5 erase poll bit7 zero", s1, 0);
        chk(s1[6] != s2[6], "R6 toggle during erase", s2[6], !s1[6]);
      end
      busy_len(n);
      for (int a = 0; a < DEPTH; a++) if (sect_of(a) == s) model[a] = 16'hFFFF;
      check_all($sformatf("R9 sector %0d erase", s));
    end

    // R10 / R11: chip erase with boot sectors locked
    prog(0, 16'h1234); busy_len(n);
    prog(100, 16'h1234); busy_len(n);
    prog(250, 16'h1234); busy_len(n);
    prog(255, 16'h1234); busy_len(n);
    prog(254, 16'h1234); busy_len(n);
    model[250] = 16'h1234; model[255] = 16'h1234; model[254] = 16'h1234;
    sec_lock = 35'hF << 31;
    erase_pre(); wr(8'h55, 8'h10);
    busy_len(n);
    for (int a = 0; a < DEPTH; a++) if (sect_of(a) < 31) model[a] = 16'hFFFF;
    check_all("R10 R11 chip erase skips locked sectors");
    sec_lock = '0;

    // R12 / R13 / R14: suspend between preprogram and erase passes
    erase_pre(); wr(254, 8'h30);
    repeat (ERASE_DLY + DEPTH + 20) @(negedge clk);
    wr(0, 8'hB0);
    chk(busy_o == 1'b0, "R13 suspend drops busy", busy_o, 0);
    rd(254, v);
    chk(v == 16'h0000, "R12 preprogram zeros", v, 0);
    rd(255, v);
    chk(v == 16'h0000, "R12 preprogram zeros second word", v, 0);
    rd(253, v);
    chk(v == model[253], "R13 read outside erase", v, model[253]);
    prog(20, 16'h1357); busy_len(n);
    chk(n == PROG_CYC, "R13 program in suspend", n, PROG_CYC);
    model[20] = 16'h1357;
    prog(255, 16'h0000);
    chk(busy_o == 1'b0, "R14 program to erasing sector inhibited", busy_o, 0);
    wr(0, 8'h30);
    chk(busy_o == 1'b1, "R13 resume raises busy", busy_o, 1);
    busy_len(n);
    model[254] = 16'hFFFF; model[255] = 16'hFFFF;
    check_all("R13 erase completes after resume");

    // R8: reset aborts a program
    prog(40, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R8 busy cleared by reset", busy_o, 0);
    rd(40, v);
    chk(v == model[40], "R8 aborted word unchanged", v, model[40]);
    prog(40, 16'h00FF); busy_len(n);
    model[40] = model[40] & 16'h00FF;
    rd(40, v);
    chk(v == model[40], "R8 program after reset", v, model[40]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule